// File: doc/BRIEF.md
# Non-Maskable Interrupt Arbiter

This block sits between two non-maskable request sources and a CPU core. The first source is an external interrupt pin. It is resynchronised and passed through an edge detector whose sensitivity is set by a 2-bit mode input. The second source is a watchdog overflow strobe. That strobe counts as a request only when the watchdog mode field selects interrupt operation. The block chooses between the two sources with a fixed priority. It records which source is being serviced and which is waiting, and it issues a one-cycle acknowledge with a vector select bit.

The core returns two things. The first is its non-maskable-in-progress flag, which decides whether a watchdog request may break into a running pin handler. The second is a return strobe, which ends the service and lets waiting requests through. No global interrupt-disable input exists, so the maskable-interrupt state of the core has no effect on this block. Each source has a single pending flag, and repeated requests of the same source merge into it.

Top module: `nmi_arbiter`

## Requirements
- R1: The pin edge mode encodes 01 = rising, 10 = falling and 11 = both edges. An edge of the selected kind on an idle block produces an acknowledge with vector 0. An edge of the other kind produces no acknowledge.
- R2: With edge mode 00 the pin is ignored. No pin transition in either direction produces an acknowledge.
- R3: A watchdog overflow strobe is a request only while the watchdog mode field equals 01. With any other value the strobe produces no acknowledge.
- R4: When a watchdog request and a pin edge are detected in the same cycle, the block acknowledges the watchdog (vector 1) and drops the pin request. That pin request is not issued after the return strobe.
- R5: A pin edge detected during any non-maskable service is held pending, whatever the NP flag holds. It is acknowledged only after the return strobe.
- R6: A watchdog request during a pin service with NP = 1, or during a watchdog service, is held pending. It is acknowledged with vector 1 after the return strobe.
- R7: A watchdog request during a pin service with NP = 0 is acknowledged at once with vector 1, one clock after the strobe. This preempts the pin handler, and the preempted pin service is not resumed.
- R8: When both sources are pending at the return strobe, the watchdog is acknowledged first. The pin is acknowledged after the next return strobe.
- R9: Each source keeps one pending entry. Several requests of the same source during one service yield a single acknowledge after the return strobe.
- R10: The acknowledge is a one-cycle pulse. The vector select is 0 for the pin and 1 for the watchdog. A pin transition is acknowledged SYNC_STAGES + 1 clocks after it is sampled.
- R11: After reset, with the pin held at its idle level, no acknowledge is produced. Releasing reset creates no false edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_pin | input | 1 | Asynchronous external interrupt pin |
| edge_mode | input | 2 | Pin edge select: 00 none, 01 rising, 10 falling, 11 both |
| wdt_ovf | input | 1 | Watchdog overflow strobe |
| wdt_mode | input | 2 | Watchdog mode field; 01 selects interrupt operation |
| np_flag | input | 1 | Core non-maskable-in-progress flag |
| reti | input | 1 | Return-from-interrupt strobe from the core |
| ack | output | 1 | One-cycle acknowledge request to the core |
| ack_vec | output | 1 | Vector select qualifying ack: 0 pin, 1 watchdog |

## Verification
The bench builds the block with SYNC_STAGES = 2 and PIN_IDLE = 0. The pin-to-acknowledge latency is therefore three clocks. This short latency lets the bench line up a pin edge and a watchdog strobe in the same detection cycle, which is how the simultaneous-request drop is tested. An idle level of 0 means reset with the pin held low must stay silent. It also means a rising edge is the natural way to open a pin service. Nested requests are then placed inside that service with NP held at 1 and then at 0.

// File: rtl/nmi_arbiter.sv
module nmi_arbiter #(
  parameter int   SYNC_STAGES = 2,
  parameter logic PIN_IDLE    = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nmi_pin,
  input  logic [1:0] edge_mode,
  input  logic       wdt_ovf,
  input  logic [1:0] wdt_mode,
  input  logic       np_flag,
  input  logic       reti,
  output logic       ack,
  output logic       ack_vec
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         pin_d;
  logic         pin_now;
  logic         pin_ev;
  logic         wdt_ev;
  logic         pin_req;
  logic         wdt_cand;
  logic         pin_cand;
  logic         preempt;
  logic         issue_wdt;
  logic         issue_pin;
  logic         svc;
  logic         svc_src;
  logic         pend_wdt;
  logic         pend_pin;

  generate
    if (SYNC_STAGES > 1) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= {SYNC_STAGES{PIN_IDLE}};
        else        sync_q <= {sync_q[MSB-1:0], nmi_pin};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= PIN_IDLE;
        else        sync_q <= nmi_pin;
      end
    end
  endgenerate

  assign pin_now = sync_q[MSB];

  always_ff @(posedge clk) begin
    if (!rst_n) pin_d <= PIN_IDLE;
    else        pin_d <= pin_now;
  end

  always_comb begin
    case (edge_mode)
      2'b01:   pin_ev = pin_now & ~pin_d;
      2'b10:   pin_ev = ~pin_now & pin_d;
      2'b11:   pin_ev = pin_now ^ pin_d;
      default: pin_ev = 1'b0;
    endcase
  end

  assign wdt_ev    = wdt_ovf && (wdt_mode == 2'b01);
  assign pin_req   = pin_ev && !wdt_ev;
  assign wdt_cand  = wdt_ev || pend_wdt;
  assign pin_cand  = pin_req || pend_pin;
  assign preempt   = svc && !reti && !svc_src && !np_flag && wdt_cand;
  assign issue_wdt = (!svc && wdt_cand) || preempt;
  assign issue_pin = !svc && !wdt_cand && pin_cand;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      svc      <= 1'b0;
      svc_src  <= 1'b0;
      pend_wdt <= 1'b0;
      pend_pin <= 1'b0;
      ack      <= 1'b0;
      ack_vec  <= 1'b0;
    end else begin
      pend_wdt <= issue_wdt ? 1'b0 : wdt_cand;
      pend_pin <= issue_pin ? 1'b0 : pin_cand;
      if (issue_wdt || issue_pin) svc <= 1'b1;
      else if (reti)              svc <= 1'b0;
      if (issue_wdt)      svc_src <= 1'b1;
      else if (issue_pin) svc_src <= 1'b0;
      ack     <= issue_wdt || issue_pin;
      ack_vec <= issue_wdt;
    end
  end

  a_r10_ack_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> svc);

  a_r5_pin_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (svc && !reti) |=> !(ack && !ack_vec));

  a_r6_wdt_held: assert property (@(posedge clk) disable iff (!rst_n)
    (svc && (svc_src || np_flag) && !reti) |=> !(ack && ack_vec));

  a_r4_wdt_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_ev |=> !(ack && !ack_vec));

  a_r3_wdt_source: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_vec) |-> ($past(wdt_ovf && (wdt_mode == 2'b01)) || $past(pend_wdt)));
endmodule

// File: tb/sim_nmi_arbiter.sv
module sim_nmi_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nmi_pin = 1'b0;
  logic [1:0] edge_mode = 2'b11;
  logic       wdt_ovf = 1'b0;
  logic [1:0] wdt_mode = 2'b01;
  logic       np_flag = 1'b1;
  logic       reti = 1'b0;
  logic       ack;
  logic       ack_vec;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nmi_arbiter #(.SYNC_STAGES(2), .PIN_IDLE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .edge_mode(edge_mode),
    .wdt_ovf(wdt_ovf), .wdt_mode(wdt_mode), .np_flag(np_flag), .reti(reti),
    .ack(ack), .ack_vec(ack_vec));

  // {mode[1:0], from, to, expect}
  localparam logic [4:0] TBL [8] = '{
    5'b01_0_1_1, 5'b01_1_0_0, 5'b10_1_0_1, 5'b10_0_1_0,
    5'b11_0_1_1, 5'b11_1_0_1, 5'b00_0_1_0, 5'b00_1_0_0};

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic watch(input int n, output int cnt, output int vec);
    cnt = 0; vec = -1;
    repeat (n) begin
      @(negedge clk);
      if (ack) begin cnt++; vec = int'(ack_vec); end
    end
  endtask

  task automatic wdt_watch(input int n, output int cnt, output int vec);
    int c2, v2;
    wdt_ovf = 1'b1;
    watch(1, cnt, vec);
    wdt_ovf = 1'b0;
    watch(n, c2, v2);
    cnt += c2;
    if (v2 >= 0) vec = v2;
  endtask

  task automatic reti_watch(input int n, output int cnt, output int vec);
    int c2, v2;
    reti = 1'b1;
    watch(1, cnt, vec);
    reti = 1'b0;
    watch(n, c2, v2);
    cnt += c2;
    if (v2 >= 0) vec = v2;
  endtask

  task automatic enter_pin_svc(input string tag);
    int c, v;
    edge_mode = 2'b01;
    nmi_pin = 1'b0;
    tick(6);
    nmi_pin = 1'b1;
    watch(6, c, v);
    check({tag, " enter count"}, c, 1);
    check({tag, " enter vec"}, v, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog timeout got=%0d exp=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c, v;
    // R11: reset with pin at idle level
    tick(4);
    check("R11 ack during reset", int'(ack), 0);
    rst_n = 1'b1;
    watch(8, c, v);
    check("R11 no false edge after reset", c, 0);

    // R1 / R2: edge mode table
    for (int i = 0; i < 8; i++) begin
      int cnt, vec;
      edge_mode = 2'b00;
      nmi_pin = TBL[i][2];
      tick(6);
      edge_mode = TBL[i][4:3];
      tick(1);
      nmi_pin = TBL[i][1];
      watch(6, cnt, vec);
      check($sformatf("R1 R2 edge entry %0d count", i), cnt, int'(TBL[i][0]));
      if (TBL[i][0]) check($sformatf("R10 edge entry %0d vec", i), vec, 0);
      reti_watch(3, cnt, vec);
    end

    // R10: latency of a pin edge
    edge_mode = 2'b01; nmi_pin = 1'b0; tick(6);
    nmi_pin = 1'b1;
    watch(2, c, v);
    check("R10 no ack before latency", c, 0);
    tick(1);
    check("R10 ack at latency", int'(ack), 1);
    tick(1);
    check("R10 ack single cycle", int'(ack), 0);
    reti_watch(3, c, v);

    // R3: watchdog mode gating
    wdt_mode = 2'b00;
    wdt_watch(5, c, v);
    check("R3 gated mode 00", c, 0);
    wdt_mode = 2'b11;
    wdt_watch(5, c, v);
    check("R3 gated mode 11", c, 0);
    wdt_mode = 2'b01;
    wdt_watch(5, c, v);
    check("R3 mode 01 count", c, 1);
    check("R10 watchdog vec", v, 1);
    reti_watch(5, c, v);
    check("R3 nothing after return", c, 0);

    // R4: simultaneous pin edge and watchdog
    edge_mode = 2'b01; nmi_pin = 1'b0; tick(6);
    nmi_pin = 1'b1;
    tick(2);
    wdt_watch(5, c, v);
    check("R4 simultaneous count", c, 1);
    check("R4 simultaneous vec", v, 1);
    reti_watch(6, c, v);
    check("R4 pin dropped", c, 0);

    // R5: pin during service waits
    enter_pin_svc("R5");
    np_flag = 1'b0;
    nmi_pin = 1'b0; tick(3);
    nmi_pin = 1'b1;
    watch(6, c, v);
    check("R5 pin held during service", c, 0);
    np_flag = 1'b1;
    reti_watch(6, c, v);
    check("R5 pending pin count", c, 1);
    check("R5 pending pin vec", v, 0);
    reti_watch(6, c, v);
    check("R5 queue empty", c, 0);

    // R6: watchdog held while NP = 1
    enter_pin_svc("R6");
    np_flag = 1'b1;
    wdt_watch(5, c, v);
    check("R6 watchdog held", c, 0);
    reti_watch(6, c, v);
    check("R6 pending watchdog count", c, 1);
    check("R6 pending watchdog vec", v, 1);
    wdt_watch(5, c, v);
    check("R6 watchdog held in watchdog service", c, 0);
    reti_watch(6, c, v);
    check("R6 second watchdog after return", c, 1);
    reti_watch(6, c, v);
    check("R6 queue empty", c, 0);

    // R7: preemption with NP = 0
    enter_pin_svc("R7");
    np_flag = 1'b0;
    wdt_ovf = 1'b1;
    tick(1);
    wdt_ovf = 1'b0;
    check("R7 immediate ack", int'(ack), 1);
    check("R7 immediate vec", int'(ack_vec), 1);
    np_flag = 1'b1;
    reti_watch(6, c, v);
    check("R7 pin service not resumed", c, 0);

    // R8: both pending, watchdog first
    enter_pin_svc("R8");
    nmi_pin = 1'b0; tick(3);
    nmi_pin = 1'b1; tick(6);
    wdt_watch(5, c, v);
    check("R8 both held", c, 0);
    reti_watch(6, c, v);
    check("R8 first count", c, 1);
    check("R8 first is watchdog", v, 1);
    reti_watch(6, c, v);
    check("R8 second count", c, 1);
    check("R8 second is pin", v, 0);
    reti_watch(6, c, v);
    check("R8 queue empty", c, 0);

    // R9: merging of same-source requests
    enter_pin_svc("R9");
    for (int k = 0; k < 3; k++) begin
      nmi_pin = 1'b0; tick(3);
      nmi_pin = 1'b1; tick(4);
    end
    reti_watch(6, c, v);
    check("R9 merged pin count", c, 1);
    reti_watch(6, c, v);
    check("R9 no second pin", c, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule